// File: doc/BRIEF.md
# Endpoint Base Address Register Bank

This block holds the six base address registers of a device's configuration header and decides which of them, if any, claims an inbound memory request. Each slot has a region size that is fixed when the block is built. Configuration software and firmware read and write the slots through a simple word-wide register port. Address bits below a slot's size are tied to zero. Because of this, a write of all ones reads back as a size mask, and software can learn each region's size by writing ones and then writing back the value it saved.

A memory slot can be built as the lower half of a 64-bit register. In that case the following slot holds address bits 63:32 of the same region. Slots can also be built as I/O slots, which only carry a type indicator, or as unused slots, which read as zero. On the request side, a memory address is compared against every programmed region. When the memory-space enable input is set, the lowest-numbered matching slot is reported one cycle later.

Top module: `ep_bar_bank`

## Requirements
- R1: While reset is asserted, and directly after it, `cfg_rvalid` and `hit_valid` are 0 and `hit_bar` is 0. Every slot's stored base is zero, so each slot reads back only its attribute bits.
- R2: A read with `cfg_rd_en` at byte offset 0x10 + 4*i (i = 0..5, bits 1:0 ignored) returns slot i on `cfg_rdata`, with `cfg_rvalid` high for exactly one cycle, one cycle after the request. A read at any other offset returns 0 with `cfg_rvalid` still pulsed.
- R3: A write with `cfg_wr_en` at a slot's offset stores the base. The value reads back with every bit below the slot's size (2^SIZE_LOG2 bytes) forced to zero.
- R4: Writing 0xFFFFFFFF to a sized slot makes it read back the two's-complement size mask with the attribute bits ORed in. Writing back the saved value then restores the earlier readback exactly.
- R5: The low bits are read-only attributes and ignore writes. Bit 0 is 1 for an I/O slot and 0 for a memory slot. Bits 2:1 are 10b for the lower half of a 64-bit slot and 00b otherwise. Bit 3 reads 0.
- R6: The slot after a 64-bit lower half is fully writable and holds address bits 63:32 of that region. It reads back exactly as written and is never reported on `hit_bar`.
- R7: A slot built with SIZE_LOG2 = 0 reads as 0 regardless of writes and never claims a request.
- R8: When `req_valid` is high, `hit_valid` goes to 1 one cycle later if `req_addr` lies in [base, base + size) of a memory slot, and `hit_bar` gives that slot's index. For a 32-bit slot, address bits 63:32 must be zero. For a 64-bit slot, they must equal the upper slot. Otherwise `hit_valid` is 0 and `hit_bar` is 0.
- R9: While `mem_en` is 0, no request produces `hit_valid`.
- R10: I/O slots never claim a memory request.
- R11: When several regions contain the address, the lowest slot index is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_rd_en | input | 1 | Configuration read strobe |
| cfg_addr | input | 12 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rvalid | output | 1 | Read data valid, one cycle after `cfg_rd_en` |
| cfg_rdata | output | 32 | Read data |
| mem_en | input | 1 | Memory-space enable; gates every hit |
| req_valid | input | 1 | Inbound memory request valid |
| req_addr | input | 64 | Inbound memory request address |
| hit_valid | output | 1 | Request claimed, one cycle after `req_valid` |
| hit_bar | output | 3 | Index of the claiming slot |

## Verification
A stored base that is corrupted, or a write mask that is wrong, appears on `cfg_rdata` on the next read of that slot, one cycle after the read strobe. It also appears on `hit_valid` and `hit_bar` one cycle after the first request near that region's edges. A slot type that is decoded wrongly shows at once in the attribute bits and in the size-probe mask. A faulty priority or enable gate shows on the first overlapping or disabled request. The bench therefore probes each region at both boundaries and just outside them, and it repeats the probe-and-restore sequence on every kind of slot.

// File: rtl/bar_pkg.sv
package bar_pkg;

    localparam int NUM_BAR   = 6;
    localparam int IDX_W     = $clog2(NUM_BAR);
    localparam int CFG_AW    = 12;
    localparam int DATA_W    = 32;
    localparam int REQ_AW    = 64;
    localparam int FIRST_OFF = 'h10;

    typedef enum logic [2:0] {
        SLOT_OFF,
        SLOT_MEM32,
        SLOT_MEM64_LO,
        SLOT_MEM64_HI,
        SLOT_IO
    } slot_kind_t;

    // bits of a slot that hold base address state
    function automatic logic [DATA_W-1:0] wr_mask(slot_kind_t kind, int unsigned lg);
        logic [DATA_W-1:0] ones;
        ones = '1;
        case (kind)
            SLOT_OFF:      return '0;
            SLOT_MEM64_HI: return '1;
            SLOT_IO:       return (ones << lg) & ~DATA_W'(32'h3);
            default:       return (ones << lg) & ~DATA_W'(32'hF);
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] attr_bits(slot_kind_t kind);
        case (kind)
            SLOT_MEM64_LO: return DATA_W'(32'h4);
            SLOT_IO:       return DATA_W'(32'h1);
            default:       return '0;
        endcase
    endfunction

    typedef struct packed {
        logic [DATA_W-1:0] base;
    } slot_state_t;

    typedef struct packed {
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
        logic              hvalid;
        logic [IDX_W-1:0]  hidx;
    } bank_state_t;

endpackage

// File: rtl/bar_slot.sv
module bar_slot
    import bar_pkg::*;
#(
    parameter slot_kind_t  KIND      = SLOT_OFF,
    parameter int unsigned SIZE_LOG2 = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_val,
    output logic [DATA_W-1:0] base_val
);

    localparam logic [DATA_W-1:0] WMASK = wr_mask(KIND, SIZE_LOG2);
    localparam logic [DATA_W-1:0] ATTR  = attr_bits(KIND);

    slot_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.base = wdata & WMASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign base_val = st_q.base;
    assign rd_val   = st_q.base | ATTR;

endmodule

// File: rtl/bar_match.sv
module bar_match
    import bar_pkg::*;
#(
    parameter slot_kind_t  KIND      = SLOT_OFF,
    parameter int unsigned SIZE_LOG2 = 0
) (
    input  logic [REQ_AW-1:0] addr,
    input  logic [DATA_W-1:0] lo_base,
    input  logic [DATA_W-1:0] hi_base,
    output logic              match
);

    localparam logic [DATA_W-1:0] CMASK = wr_mask(KIND, SIZE_LOG2);

    logic low_eq;
    logic high_eq;

    always_comb begin
        low_eq  = (((addr[DATA_W-1:0] ^ lo_base) & CMASK) == '0);
        high_eq = 1'b0;
        match   = 1'b0;
        case (KIND)
            SLOT_MEM32: begin
                high_eq = (addr[REQ_AW-1:DATA_W] == '0);
                match   = low_eq && high_eq;
            end
            SLOT_MEM64_LO: begin
                high_eq = (addr[REQ_AW-1:DATA_W] == hi_base);
                match   = low_eq && high_eq;
            end
            default: match = 1'b0;
        endcase
    end

endmodule

// File: rtl/bar_prio.sv
module bar_prio #(
    parameter int N     = 6,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/ep_bar_bank.sv
module ep_bar_bank
    import bar_pkg::*;
#(
    parameter int unsigned        SIZE_LOG2 [NUM_BAR] = '{12, 0, 20, 0, 8, 0},
    parameter logic [NUM_BAR-1:0] IS64                = 6'b000100,
    parameter logic [NUM_BAR-1:0] IS_IO               = 6'b010000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_rd_en,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              cfg_rvalid,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              mem_en,
    input  logic              req_valid,
    input  logic [REQ_AW-1:0] req_addr,
    output logic              hit_valid,
    output logic [IDX_W-1:0]  hit_bar
);

    localparam int WORD_W = CFG_AW - 2;
    localparam logic [WORD_W-1:0] FIRST_WORD = WORD_W'(FIRST_OFF / 4);
    localparam logic [NUM_BAR-1:0] UPPER =
        {IS64[NUM_BAR-2:0] & ~IS_IO[NUM_BAR-2:0], 1'b0};

    logic [WORD_W-1:0]  word;
    logic [WORD_W-1:0]  rel;
    logic               in_rng;
    logic [IDX_W-1:0]   sel;
    logic [NUM_BAR-1:0] wr_sel;
    logic [DATA_W-1:0]  slot_rd   [NUM_BAR];
    logic [DATA_W-1:0]  slot_base [NUM_BAR];
    logic [NUM_BAR-1:0] slot_hit;
    logic               any_hit;
    logic [IDX_W-1:0]   hit_idx;

    assign word   = cfg_addr[CFG_AW-1:2];
    assign rel    = word - FIRST_WORD;
    assign in_rng = (word >= FIRST_WORD) && (rel < WORD_W'(NUM_BAR));
    assign sel    = rel[IDX_W-1:0];

    for (genvar i = 0; i < NUM_BAR; i++) begin : g_slot
        localparam slot_kind_t KIND =
            UPPER[i]            ? SLOT_MEM64_HI :
            (SIZE_LOG2[i] == 0) ? SLOT_OFF      :
            IS_IO[i]            ? SLOT_IO       :
            IS64[i]             ? SLOT_MEM64_LO : SLOT_MEM32;

        logic [DATA_W-1:0] hi_src;

        assign wr_sel[i] = cfg_wr_en && in_rng && (sel == IDX_W'(i));

        bar_slot #(
            .KIND      (KIND),
            .SIZE_LOG2 (SIZE_LOG2[i])
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_sel[i]),
            .wdata    (cfg_wdata),
            .rd_val   (slot_rd[i]),
            .base_val (slot_base[i])
        );

        if (i < NUM_BAR - 1) begin : g_hi
            assign hi_src = slot_base[i+1];
        end else begin : g_hi_none
            assign hi_src = '0;
        end

        bar_match #(
            .KIND      (KIND),
            .SIZE_LOG2 (SIZE_LOG2[i])
        ) u_match (
            .addr    (req_addr),
            .lo_base (slot_base[i]),
            .hi_base (hi_src),
            .match   (slot_hit[i])
        );
    end

    bar_prio #(
        .N     (NUM_BAR),
        .IDX_W (IDX_W)
    ) u_prio (
        .req (slot_hit),
        .any (any_hit),
        .idx (hit_idx)
    );

    bank_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = cfg_rd_en;
        st_d.rdata  = '0;
        if (cfg_rd_en && in_rng) begin
            st_d.rdata = slot_rd[sel];
        end
        st_d.hvalid = req_valid && mem_en && any_hit;
        st_d.hidx   = (req_valid && mem_en && any_hit) ? hit_idx : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_rvalid = st_q.rvalid;
    assign cfg_rdata  = st_q.rdata;
    assign hit_valid  = st_q.hvalid;
    assign hit_bar    = st_q.hidx;

endmodule

// File: rtl/ep_bar_bank_chk.sv
module ep_bar_bank_chk
    import bar_pkg::*;
#(
    parameter int unsigned        SIZE_LOG2 [NUM_BAR] = '{12, 0, 20, 0, 8, 0},
    parameter logic [NUM_BAR-1:0] IS64                = 6'b000100,
    parameter logic [NUM_BAR-1:0] IS_IO               = 6'b010000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_rd_en,
    input logic              cfg_rvalid,
    input logic              mem_en,
    input logic              req_valid,
    input logic              hit_valid,
    input logic [IDX_W-1:0]  hit_bar
);

    localparam int SPAN = 2 ** IDX_W;
    localparam logic [NUM_BAR-1:0] PREV64 = {IS64[NUM_BAR-2:0], 1'b0};

    logic [SPAN-1:0] never_hit;

    always_comb begin
        for (int k = 0; k < SPAN; k++) begin
            if (k >= NUM_BAR) begin
                never_hit[k] = 1'b1;
            end else begin
                never_hit[k] = (SIZE_LOG2[k] == 0) || IS_IO[k] || PREV64[k];
            end
        end
    end

    // R2: each read strobe yields exactly one valid cycle
    a_r2_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_en |=> cfg_rvalid);
    a_r2_rvalid_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rvalid |-> $past(cfg_rd_en));

    // R8: a claim only follows a request
    a_r8_hit_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> $past(req_valid));
    // R8: misses report index zero
    a_r8_miss_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_valid |-> (hit_bar == '0));

    // R9: enable gates every claim
    a_r9_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> $past(mem_en));

    // R7: unused, I/O (R10) and upper-half (R6) slots are never reported
    a_r7_claimable_slot: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> !never_hit[hit_bar]);

endmodule

bind ep_bar_bank ep_bar_bank_chk #(
    .SIZE_LOG2 (SIZE_LOG2),
    .IS64      (IS64),
    .IS_IO     (IS_IO)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_rd_en  (cfg_rd_en),
    .cfg_rvalid (cfg_rvalid),
    .mem_en     (mem_en),
    .req_valid  (req_valid),
    .hit_valid  (hit_valid),
    .hit_bar    (hit_bar)
);

// File: tb/ep_bar_bank_bench.sv
module ep_bar_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_rd_en = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_rvalid;
    logic [31:0] cfg_rdata;
    logic        mem_en = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic        hit_valid;
    logic [2:0]  hit_bar;

    int n_cmp = 0;
    int n_bad = 0;
    logic req_seen = 1'b0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] data;
        string       tag;
    } rd_exp_t;

    typedef struct {
        logic        v;
        logic [2:0]  idx;
        string       tag;
    } hit_exp_t;

    rd_exp_t  rd_q[$];
    hit_exp_t hit_q[$];

    always #5 clk = ~clk;

    ep_bar_bank u_ep_bar_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_rd_en  (cfg_rd_en),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rvalid (cfg_rvalid),
        .cfg_rdata  (cfg_rdata),
        .mem_en     (mem_en),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .hit_valid  (hit_valid),
        .hit_bar    (hit_bar)
    );

    always @(posedge clk) req_seen <= req_valid;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pop and compare as results appear
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (cfg_rvalid) begin
                if (rd_q.size() == 0) begin
                    check(1'b0, "R2 unexpected read data", 64'(cfg_rdata), 64'h0);
                end else begin
                    rd_exp_t e;
                    e = rd_q.pop_front();
                    check(cfg_rdata === e.data, e.tag, 64'(cfg_rdata), 64'(e.data));
                end
            end
            if (req_seen) begin
                if (hit_q.size() == 0) begin
                    check(1'b0, "R8 unexpected request result", 64'(hit_valid), 64'h0);
                end else begin
                    hit_exp_t h;
                    h = hit_q.pop_front();
                    check({hit_valid, hit_bar} === {h.v, h.idx}, h.tag,
                          64'({hit_valid, hit_bar}), 64'({h.v, h.idx}));
                end
            end else if (hit_valid) begin
                check(1'b0, "R8 hit without request", 64'(hit_valid), 64'h0);
            end
        end
    end

    task automatic cfg_write(input logic [11:0] off, input logic [31:0] d);
        cfg_wr_en = 1'b1;
        cfg_addr  = off;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic cfg_read(input logic [11:0] off, input logic [31:0] exp,
                            input string tag);
        rd_exp_t e;
        e.data = exp;
        e.tag  = tag;
        rd_q.push_back(e);
        cfg_rd_en = 1'b1;
        cfg_addr  = off;
        @(negedge clk);
        cfg_rd_en = 1'b0;
    endtask

    task automatic mem_req(input logic [63:0] a, input logic v, input logic [2:0] idx,
                           input string tag);
        hit_exp_t h;
        h.v   = v;
        h.idx = idx;
        h.tag = tag;
        hit_q.push_back(h);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            check(1'b0, "watchdog expired", 64'h0, 64'h1);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        check(cfg_rvalid === 1'b0 && hit_valid === 1'b0 && hit_bar === 3'd0,
              "R1 outputs in reset", 64'({cfg_rvalid, hit_valid, hit_bar}), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cfg_rvalid === 1'b0 && hit_valid === 1'b0,
              "R1 outputs after reset", 64'({cfg_rvalid, hit_valid}), 64'h0);

        // R1 R5: reset readback is attribute bits only
        cfg_read(12'h010, 32'h0000_0000, "R1 slot0 reset");
        cfg_read(12'h014, 32'h0000_0000, "R1 slot1 reset");
        cfg_read(12'h018, 32'h0000_0004, "R5 slot2 64-bit type");
        cfg_read(12'h01C, 32'h0000_0000, "R1 slot3 reset");
        cfg_read(12'h020, 32'h0000_0001, "R5 slot4 io flag");
        cfg_read(12'h024, 32'h0000_0000, "R1 slot5 reset");
        // R2: outside the section, and low offset bits ignored
        cfg_read(12'h000, 32'h0, "R2 offset 0x00");
        cfg_read(12'h028, 32'h0, "R2 offset 0x28");
        cfg_read(12'h01A, 32'h0000_0004, "R2 low addr bits ignored");

        // R4: probe and restore on every kind
        cfg_write(12'h010, 32'hFFFF_FFFF);
        cfg_read(12'h010, 32'hFFFF_F000, "R4 slot0 size mask");
        cfg_write(12'h010, 32'h0);
        cfg_read(12'h010, 32'h0, "R4 slot0 restored");
        cfg_write(12'h018, 32'hFFFF_FFFF);
        cfg_write(12'h01C, 32'hFFFF_FFFF);
        cfg_read(12'h018, 32'hFFF0_0004, "R4 slot2 size mask");
        cfg_read(12'h01C, 32'hFFFF_FFFF, "R6 upper all ones");
        cfg_write(12'h020, 32'hFFFF_FFFF);
        cfg_read(12'h020, 32'hFFFF_FF01, "R4 slot4 io size mask");
        cfg_write(12'h014, 32'hFFFF_FFFF);
        cfg_read(12'h014, 32'h0, "R7 slot1 size zero probe");

        // R3 R5: programming with stray low bits
        cfg_write(12'h010, 32'h8000_0ABC);
        cfg_read(12'h010, 32'h8000_0000, "R3 slot0 low bits cleared");
        cfg_write(12'h010, 32'h8000_1FFF);
        cfg_read(12'h010, 32'h8000_1000, "R5 slot0 attrs read-only");
        cfg_write(12'h018, 32'h1234_5678);
        cfg_read(12'h018, 32'h1230_0004, "R3 slot2 base");
        cfg_write(12'h01C, 32'h0000_0001);
        cfg_read(12'h01C, 32'h0000_0001, "R6 upper exact");
        cfg_write(12'h020, 32'h0000_C0FF);
        cfg_read(12'h020, 32'h0000_C001, "R5 slot4 io base");
        cfg_write(12'h024, 32'h5000_0000);
        cfg_read(12'h024, 32'h0, "R7 slot5 ignores write");
        cfg_read(12'h014, 32'h0, "R7 slot1 still zero");

        // R9: disabled space
        mem_req(64'h0000_0000_8000_1000, 1'b0, 3'd0, "R9 disabled no hit");
        mem_en = 1'b1;

        // R8: region edges
        mem_req(64'h0000_0000_8000_1000, 1'b1, 3'd0, "R8 slot0 low edge");
        mem_req(64'h0000_0000_8000_1FFF, 1'b1, 3'd0, "R8 slot0 high edge");
        mem_req(64'h0000_0000_8000_2000, 1'b0, 3'd0, "R8 slot0 past end");
        mem_req(64'h0000_0000_8000_0FFF, 1'b0, 3'd0, "R8 slot0 before base");
        mem_req(64'h0000_0001_8000_1000, 1'b0, 3'd0, "R8 slot0 upper bits set");
        mem_req(64'h0000_0001_1230_0000, 1'b1, 3'd2, "R8 slot2 low edge");
        mem_req(64'h0000_0001_123F_FFFF, 1'b1, 3'd2, "R8 slot2 high edge");
        mem_req(64'h0000_0001_1240_0000, 1'b0, 3'd0, "R8 slot2 past end");
        mem_req(64'h0000_0000_1230_0000, 1'b0, 3'd0, "R6 slot2 wrong upper");
        mem_req(64'h0000_0000_0000_C000, 1'b0, 3'd0, "R10 io slot no claim");
        mem_req(64'h0000_0000_0000_0000, 1'b0, 3'd0, "R7 size zero no claim");

        // R11: overlapping regions
        cfg_write(12'h01C, 32'h0);
        cfg_write(12'h010, 32'h1230_0000);
        cfg_read(12'h010, 32'h1230_0000, "R3 slot0 reprogram");
        mem_req(64'h0000_0000_1230_0010, 1'b1, 3'd0, "R11 lowest index wins");
        mem_req(64'h0000_0000_1230_1000, 1'b1, 3'd2, "R11 only slot2");
        mem_en = 1'b0;
        mem_req(64'h0000_0000_1230_0010, 1'b0, 3'd0, "R9 enable cleared");

        repeat (4) @(negedge clk);
        check(rd_q.size() == 0, "R2 reads outstanding", 64'(rd_q.size()), 64'h0);
        check(hit_q.size() == 0, "R8 requests outstanding", 64'(hit_q.size()), 64'h0);
        if (!finished) begin
            finished = 1'b1;
            summary();
            $finish;
        end
    end

endmodule